// File: doc/BRIEF.md
# SDRAM Start-Up and Refresh Sequencer

This block sits at the front of an SDR SDRAM controller and owns the command bus from reset until the memory is usable. After reset it keeps the bus quiet with clock enable and the data mask high for the power stabilisation time. It then closes every bank, runs a burst of auto-refresh cycles, programs the mode register and finally raises a ready flag. All delays are set in nanoseconds as parameters and turned into whole clock cycles, rounding up.

Once ready is high the block keeps the refresh rate. An interval timer raises a refresh request. The host scheduler answers with an acknowledge once all banks are idle, and the sequencer then puts an auto-refresh on the bus. Read and write traffic and data capture belong to other blocks.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is asserted, and for STABLE_CYC cycles after it is released, the bus carries only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with cke=1, dqm=1, ready=0 and refresh_req=0. cke and dqm stay high until ready rises.
- R2: A precharge-all command (cs_n=0, ras_n=0, cas_n=1, we_n=0 with addr[10]=1) appears exactly STABLE_CYC cycles after reset release. STABLE_CYC is the stabilisation time divided by the clock period, rounded up.
- R3: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1) follows the precharge-all by exactly RP_CYC cycles.
- R4: Exactly REF_COUNT start-up refreshes are issued, each RFC_CYC cycles after the one before it.
- R5: A mode register set (all four strobes low, ba=0) follows the last start-up refresh by RFC_CYC cycles. On that command addr[2:0] is the burst-length code (1→000, 2→001, 4→010, 8→011, full page→111), addr[3] is 1 for interleaved order, addr[6:4] is the CAS latency in binary, addr[9] is 1 for single-location writes, and all other address bits are 0.
- R6: ready rises exactly RSC_CYC cycles after the mode register set and then stays high until the next reset.
- R7: Between the start-up commands, and outside granted refreshes afterwards, only NOP is driven.
- R8: refresh_req rises REFI_CYC cycles after ready rises, and again every REFI_CYC cycles after that, measured from when ready rose.
- R9: While refresh_req is high it stays high until refresh_ack is sampled high. The auto-refresh then appears on the next cycle, and refresh_req falls in that same cycle.
- R10: refresh_ack has no effect while refresh_req is low, and none before ready.
- R11: Asserting reset at any time restarts the whole sequence from the stabilisation wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_ack | input | 1 | Host reports all banks idle and grants the refresh slot |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | 1 | Data mask, high until ready |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus (mode word, precharge-all flag) |
| ready | output | 1 | Start-up sequence complete |
| refresh_req | output | 1 | A refresh slot is due |

## Verification
A wrong phase or counter value inside the sequencer shows up at the command pins as a precharge, refresh or mode command on the wrong cycle. It can also show as a wrong count of refreshes, or a mode word with a field in the wrong place. Each command is matched against its expected cycle as soon as it appears, so an error shows at the first misplaced command, not at the end of the run. A lost or stuck refresh request shows within one refresh interval, as a missing or extra rise of refresh_req or an auto-refresh that did not wait for the acknowledge.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PREA,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        PH_STABLE,
        PH_WAIT_RP,
        PH_WAIT_RFC,
        PH_WAIT_RSC,
        PH_RUN,
        PH_RUN_RFC
    } phase_e;

    // Whole clock cycles covering a delay, never less than one
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins
    import sdram_boot_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    always_comb begin
        cs_n = 1'b0;
        unique case (cmd)
            CMD_PREA: {ras_n, cas_n, we_n} = 3'b010;
            CMD_REF:  {ras_n, cas_n, we_n} = 3'b001;
            CMD_MRS:  {ras_n, cas_n, we_n} = 3'b000;
            default:  {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end
endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter int CAS_LATENCY      = 3,
    parameter bit SINGLE_WRITE     = 1'b0,
    parameter int ADDR_W           = 12
) (
    output logic [ADDR_W-1:0] word
);
    localparam logic [2:0] LEN_CODE =
        (BURST_LEN == 1) ? 3'b000 :
        (BURST_LEN == 2) ? 3'b001 :
        (BURST_LEN == 4) ? 3'b010 :
        (BURST_LEN == 8) ? 3'b011 : 3'b111;
    localparam logic [2:0] LAT_CODE = 3'(CAS_LATENCY);

    always_comb begin
        word      = '0;
        word[2:0] = LEN_CODE;
        word[3]   = BURST_INTERLEAVE;
        word[6:4] = LAT_CODE;
        word[9]   = SINGLE_WRITE;
    end
endmodule

// File: rtl/sdram_interval_timer.sv
module sdram_interval_timer #(
    parameter int unsigned PERIOD = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (PERIOD < 2) ? 1 : $clog2(PERIOD);
    localparam logic [W-1:0] RELOAD = W'(PERIOD - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == '0);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = RELOAD;
        else              cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    // R8
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
    import sdram_boot_pkg::*;
#(
    parameter int unsigned CLK_PS    = 7500,
    parameter int unsigned STABLE_NS = 500000,
    parameter int unsigned T_RP_NS   = 20,
    parameter int unsigned T_RFC_NS  = 75,
    parameter int unsigned T_RSC_NS  = 15,
    parameter int unsigned T_REFI_NS = 15600,
    parameter int unsigned REF_COUNT = 8,
    parameter int BURST_LEN          = 4,
    parameter bit BURST_INTERLEAVE   = 1'b0,
    parameter int CAS_LATENCY        = 3,
    parameter bit SINGLE_WRITE       = 1'b0,
    parameter int ADDR_W             = 12,
    parameter int BA_W               = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_ack,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic              dqm,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              refresh_req
);
    localparam int unsigned STABLE_CYC = ns_to_cycles(STABLE_NS, CLK_PS);
    localparam int unsigned RP_CYC     = ns_to_cycles(T_RP_NS,   CLK_PS);
    localparam int unsigned RFC_CYC    = ns_to_cycles(T_RFC_NS,  CLK_PS);
    localparam int unsigned RSC_CYC    = ns_to_cycles(T_RSC_NS,  CLK_PS);
    localparam int unsigned REFI_CYC   = ns_to_cycles(T_REFI_NS, CLK_PS);
    localparam int unsigned MAX_CYC    = max4(STABLE_CYC, RP_CYC, RFC_CYC, RSC_CYC);
    localparam int CNT_W  = $clog2(MAX_CYC + 1);
    localparam int REFS_W = $clog2(REF_COUNT + 1);
    localparam logic [REFS_W-1:0] REFS_LAST = REFS_W'(REF_COUNT);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [REFS_W-1:0]  refs;
        cmd_e               cmd;
        logic [ADDR_W-1:0]  addr;
        logic               ready;
        logic               req;
    } seq_t;

    localparam seq_t RST_VAL = '{
        phase: PH_STABLE,
        cnt:   CNT_W'(STABLE_CYC - 1),
        refs:  '0,
        cmd:   CMD_NOP,
        addr:  '0,
        ready: 1'b0,
        req:   1'b0
    };

    seq_t seq_d, seq_q;
    logic [ADDR_W-1:0] mode_word;
    logic              interval_tick;

    sdram_mode_word #(
        .BURST_LEN(BURST_LEN), .BURST_INTERLEAVE(BURST_INTERLEAVE),
        .CAS_LATENCY(CAS_LATENCY), .SINGLE_WRITE(SINGLE_WRITE), .ADDR_W(ADDR_W)
    ) u_mode (
        .word(mode_word)
    );

    sdram_interval_timer #(.PERIOD(REFI_CYC)) u_refi (
        .clk(clk), .rst_n(rst_n), .run(seq_q.ready), .tick(interval_tick)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.addr = '0;
        unique case (seq_q.phase)
            PH_STABLE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.cmd      = CMD_PREA;
                    seq_d.addr[10] = 1'b1;
                    seq_d.cnt      = CNT_W'(RP_CYC - 1);
                    seq_d.phase    = PH_WAIT_RP;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_WAIT_RP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.refs  = REFS_W'(1);
                    seq_d.cnt   = CNT_W'(RFC_CYC - 1);
                    seq_d.phase = PH_WAIT_RFC;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_WAIT_RFC: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (seq_q.refs == REFS_LAST) begin
                    seq_d.cmd   = CMD_MRS;
                    seq_d.addr  = mode_word;
                    seq_d.cnt   = CNT_W'(RSC_CYC - 1);
                    seq_d.phase = PH_WAIT_RSC;
                end else begin
                    seq_d.cmd  = CMD_REF;
                    seq_d.refs = seq_q.refs + 1'b1;
                    seq_d.cnt  = CNT_W'(RFC_CYC - 1);
                end
            end
            PH_WAIT_RSC: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ready = 1'b1;
                    seq_d.phase = PH_RUN;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_RUN: begin
                seq_d.req = seq_q.req | interval_tick;
                if (seq_q.req && refresh_ack) begin
                    seq_d.cmd   = CMD_REF;
                    seq_d.req   = interval_tick;
                    seq_d.cnt   = CNT_W'(RFC_CYC - 1);
                    seq_d.phase = PH_RUN_RFC;
                end
            end
            PH_RUN_RFC: begin
                seq_d.req = seq_q.req | interval_tick;
                if (seq_q.cnt == '0) seq_d.phase = PH_RUN;
                else                 seq_d.cnt   = seq_q.cnt - 1'b1;
            end
            default: seq_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= RST_VAL;
        else        seq_q <= seq_d;
    end

    sdram_cmd_pins u_pins (
        .cmd(seq_q.cmd), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    assign cke         = 1'b1;
    assign dqm         = !seq_q.ready;
    assign ba          = '0;
    assign addr        = seq_q.addr;
    assign ready       = seq_q.ready;
    assign refresh_req = seq_q.req;

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ready |=> seq_q.ready);

    // R9
    ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RUN && seq_q.req && refresh_ack) |=> (seq_q.cmd == CMD_REF));

    // R10
    no_stray_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_RUN && !seq_q.req) |=> (seq_q.cmd != CMD_REF));

    // R5
    mrs_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_MRS) |-> (seq_q.refs == REFS_LAST));

    // R2
    prea_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_PREA) |-> (seq_q.addr[10] && !seq_q.ready));
endmodule

// File: tb/tb_sdram_boot_refresh.sv
`timescale 1ns/1ps
module tb_sdram_boot_refresh;
    localparam int CLK_PERIOD = 10;
    // Timing in clock cycles, rounded up from ns at a 10 ns clock
    localparam int S_CYC    = (3000 * 1000 + 9999) / 10000;   // 300
    localparam int RP_CYC   = (20 * 1000 + 9999) / 10000;     // 2
    localparam int RFC_CYC  = (75 * 1000 + 9999) / 10000;     // 8
    localparam int RSC_CYC  = (15 * 1000 + 9999) / 10000;     // 2
    localparam int REFI_CYC = (2000 * 1000 + 9999) / 10000;   // 200
    localparam int NREF     = 8;
    localparam int RDY_CYC  = S_CYC + RP_CYC + NREF * RFC_CYC + RSC_CYC;
    // BL=8 -> 011, interleaved -> A3, CL=2 -> 010, single write -> A9
    localparam logic [11:0] MODE_EXP = 12'h22B;

    localparam int K_PREA = 1, K_REF = 2, K_MRS = 3, K_READY = 4, K_REQ = 5;

    logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, dqm, ready, refresh_req;
    logic [1:0]  ba;
    logic [11:0] addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_boot_refresh #(
        .CLK_PS(10000), .STABLE_NS(3000), .T_RP_NS(20), .T_RFC_NS(75),
        .T_RSC_NS(15), .T_REFI_NS(2000), .REF_COUNT(NREF),
        .BURST_LEN(8), .BURST_INTERLEAVE(1'b1), .CAS_LATENCY(2), .SINGLE_WRITE(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .refresh_ack(ack),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .dqm(dqm), .ba(ba), .addr(addr),
        .ready(ready), .refresh_req(refresh_req)
    );

    typedef struct {
        int    kind;
        int    cyc;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    int total = 0, failed = 0;
    int cyc;
    bit init_pins_bad = 1'b0;
    logic prev_ready, prev_req;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.cyc = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_init();
        int t;
        t = S_CYC;
        push(K_PREA, t, "R2");
        t = t + RP_CYC;
        push(K_REF, t, "R3");
        for (int k = 1; k < NREF; k++) begin
            t = t + RFC_CYC;
            push(K_REF, t, "R4");
        end
        t = t + RFC_CYC;
        push(K_MRS, t, "R5");
        push(K_READY, t + RSC_CYC, "R6");
    endtask

    // Scoreboard compare of one observed event
    task automatic observe(input int kind);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected event kind", kind, 0);
            return;
        end
        e = exp_q.pop_front();
        chk(kind == e.kind, e.tag, "event kind", kind, e.kind);
        chk(cyc == e.cyc, e.tag, "event cycle", cyc, e.cyc);
        if (kind == K_PREA) chk(addr[10] == 1'b1, e.tag, "precharge-all A10", addr[10], 1);
        if (kind == K_MRS) begin
            chk(addr == MODE_EXP, e.tag, "mode word", addr, MODE_EXP);
            chk(ba == 2'b00, e.tag, "mode bank bits", ba, 0);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ready <= 1'b0;
            prev_req   <= 1'b0;
        end else begin
            case ({cs_n, ras_n, cas_n, we_n})
                4'b0111: ;
                4'b0010: observe(K_PREA);
                4'b0001: observe(K_REF);
                4'b0000: observe(K_MRS);
                default: observe(9);
            endcase
            if (ready && !prev_ready) observe(K_READY);
            if (prev_ready && !ready) chk(1'b0, "R6", "ready fell", 0, 1);
            if (refresh_req && !prev_req) observe(K_REQ);
            if (!ready && !(cke && dqm)) init_pins_bad = 1'b1;
            prev_ready <= ready;
            prev_req   <= refresh_req;
        end
    end

    task automatic wait_cyc(input int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        @(negedge clk);
        @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "reset command", {cs_n, ras_n, cas_n, we_n}, 7);
        chk(cke && dqm, "R1", "reset cke/dqm", {cke, dqm}, 3);
        chk(!ready && !refresh_req, "R1", "reset ready/req", {ready, refresh_req}, 0);
        push_init();
        rst_n = 1'b1;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        do_reset();
        // R1: still quiet just before the precharge-all
        wait_cyc(S_CYC - 1);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "nop through stabilisation",
            {cs_n, ras_n, cas_n, we_n}, 7);
        // R11: reset in the middle of the refresh burst restarts everything
        wait_cyc(S_CYC + RP_CYC + 3 * RFC_CYC + 1);
        do_reset();
        // R10: acknowledge held during start-up has no effect
        wait_cyc(5);
        ack = 1'b1;
        wait_cyc(RDY_CYC + 1);
        chk(exp_q.size() == 0, "R11", "restarted sequence complete", exp_q.size(), 0);
        chk(ready == 1'b1 && dqm == 1'b0, "R6", "ready with dqm low", {ready, dqm}, 2);
        // R10: acknowledge with no request after ready
        wait_cyc(RDY_CYC + 50);
        ack = 1'b0;
        chk(refresh_req == 1'b0, "R10", "no request yet", refresh_req, 0);
        // R8: first request one interval after ready
        push(K_REQ, RDY_CYC + REFI_CYC, "R8");
        wait_cyc(RDY_CYC + REFI_CYC + 20);
        chk(refresh_req == 1'b1, "R9", "request held pending", refresh_req, 1);
        ack = 1'b1;
        push(K_REF, RDY_CYC + REFI_CYC + 21, "R9");
        wait_cyc(RDY_CYC + REFI_CYC + 21);
        ack = 1'b0;
        chk(refresh_req == 1'b0, "R9", "request cleared by grant", refresh_req, 1'b0);
        // R9: acknowledge raised early, grant follows the request at once
        push(K_REQ, RDY_CYC + 2 * REFI_CYC, "R8");
        push(K_REF, RDY_CYC + 2 * REFI_CYC + 1, "R9");
        wait_cyc(RDY_CYC + 2 * REFI_CYC - 10);
        ack = 1'b1;
        wait_cyc(RDY_CYC + 2 * REFI_CYC + 6);
        ack = 1'b0;
        chk(exp_q.size() == 0, "R9", "early-ack refresh seen", exp_q.size(), 0);
        // R8: period holds after grants
        push(K_REQ, RDY_CYC + 3 * REFI_CYC, "R8");
        wait_cyc(RDY_CYC + 3 * REFI_CYC + 2);
        chk(exp_q.size() == 0, "R8", "third request on time", exp_q.size(), 0);
        chk(!init_pins_bad, "R1", "cke/dqm high before ready", init_pins_bad, 0);
        finish_up();
    end
endmodule